// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop is in lock by watching the two clocks that meet at its phase-frequency detector. A fast sampling clock, at least eight times the input clock rate, measures how far apart the rising edges of the reference and feedback clocks land. An edge pair closer together than a programmable window counts as good. Lock is declared only after a programmable run of good pairs in a row. A single bad pair withdraws it at once.

Both input clocks pass through two-flop synchronizers into the sampling domain. Rising edges are detected there. The first edge of a pair starts a cycle counter. The partner edge stops it and yields a pass or fail verdict. If the partner never shows up within twice the window, the pair is judged a failure. A small run counter turns these verdicts into the lock flag. The flag can be copied to any of three output pins.

Top module: `pll_lock_watch`

## Requirements
- R1: After reset, `lock_o` and all three pin outputs are low.
- R2: A pair whose edge separation, counted in sampling cycles between the detected rising edges, is less than `win_cycles` passes. A pair with a separation equal to or greater than `win_cycles` fails. Either clock may lead.
- R3: Lock rises when the count of consecutive passing pairs reaches the threshold chosen by `thr_sel`: code 0 needs 5 pairs, code 1 needs 16, code 2 needs 64 and code 3 needs 255. One pair fewer leaves lock low. The run count saturates at the threshold, and lock stays high while pairs keep passing.
- R4: A single failing pair clears lock and the run count.
- R5: A leading edge with no partner edge within 2×`win_cycles` sampling cycles counts as a failing pair.
- R6: While `enable` is low, lock is held low and the run count is cleared. After `enable` returns high, a full new run is needed.
- R7: A change of `thr_sel` clears lock and the run count.
- R8: Each pin output equals `lock_o` ANDed with its route bit: bit 0 drives `lock_pin`, bit 1 drives `status_pin` and bit 2 drives `monitor_pin`.
- R9: Rising edges that reach the sampling domain in the same cycle count as separation 0. Such a pair passes whenever `win_cycles` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous |
| fb_clk_in | input | 1 | Feedback clock, asynchronous |
| enable | input | 1 | Detector enable |
| thr_sel | input | 2 | Run-length threshold code |
| win_cycles | input | WIN_W (6) | Lock window in sampling cycles |
| route_en | input | 3 | Per-pin route enables |
| lock_o | output | 1 | Lock flag |
| lock_pin | output | 1 | Lock flag routed to the lock pin |
| status_pin | output | 1 | Lock flag routed to the status pin |
| monitor_pin | output | 1 | Lock flag routed to the reference-monitor pin |

## Verification
The hardest cases to reach from the ports are the exact window boundaries and the orphan edge. For the boundaries, separations of win−1 and win must be seen while lock is already held, so that one verdict visibly flips the flag. For the orphan case, a lone edge must time out while the partner clock stays quiet. The stimulus therefore first builds lock with simultaneous pairs. It then sends one pair at a chosen separation, with either clock leading, and sweeps the separation from 0 past twice the window for two window sizes. The threshold sweep drives exactly threshold−1 and then threshold passing pairs for every code, varying the separation below the window along the way.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef enum logic {
        MEAS_IDLE = 1'b0,
        MEAS_WAIT = 1'b1
    } meas_state_e;

    localparam int RUN_W = 8;

    localparam int PIN_LOCK    = 0;
    localparam int PIN_STATUS  = 1;
    localparam int PIN_MONITOR = 2;
    localparam int PIN_COUNT   = 3;

    function automatic logic [RUN_W-1:0] run_target(input logic [1:0] code);
        case (code)
            2'd0:    return RUN_W'(5);
            2'd1:    return RUN_W'(16);
            2'd2:    return RUN_W'(64);
            default: return RUN_W'(255);
        endcase
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/phase_window_meter.sv
module phase_window_meter
    import pll_lock_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             vrd_valid,
    output logic             vrd_pass
);
    localparam int CNT_W = WIN_W + 1;

    typedef struct packed {
        meas_state_e      st;
        logic             lead_ref;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             pass;
    } meter_t;

    meter_t d, q;
    logic             partner;
    logic [CNT_W-1:0] limit;

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        d.pass    = 1'b0;
        limit     = {win_cycles, 1'b0};
        partner   = q.lead_ref ? fb_rise : ref_rise;
        case (q.st)
            MEAS_IDLE: begin
                if (ref_rise && fb_rise) begin
                    d.valid = 1'b1;
                    d.pass  = (win_cycles != '0);
                end else if (ref_rise || fb_rise) begin
                    d.st       = MEAS_WAIT;
                    d.lead_ref = ref_rise;
                    d.cnt      = CNT_W'(1);
                end
            end
            default: begin
                if (partner) begin
                    d.valid = 1'b1;
                    d.pass  = (q.cnt < CNT_W'(win_cycles));
                    d.st    = MEAS_IDLE;
                end else if (q.cnt >= limit) begin
                    d.valid = 1'b1;
                    d.pass  = 1'b0;
                    d.st    = MEAS_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: MEAS_IDLE, lead_ref: 1'b0, cnt: '0, valid: 1'b0, pass: 1'b0};
        else        q <= d;
    end

    assign vrd_valid = q.valid;
    assign vrd_pass  = q.pass;
endmodule

// File: rtl/run_qualifier.sv
module run_qualifier
    import pll_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       thr_sel,
    input  logic             vrd_valid,
    input  logic             vrd_pass,
    output logic [RUN_W-1:0] run_cnt,
    output logic             lock
);
    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
        logic [1:0]       thr;
    } qual_t;

    qual_t d, q;
    logic [RUN_W-1:0] target;

    always_comb begin
        d      = q;
        d.thr  = thr_sel;
        target = run_target(thr_sel);
        if (!enable || (thr_sel != q.thr)) begin
            d.run  = '0;
            d.lock = 1'b0;
        end else if (vrd_valid) begin
            if (vrd_pass) begin
                d.run  = (q.run >= target) ? target : q.run + RUN_W'(1);
                d.lock = (d.run >= target);
            end else begin
                d.run  = '0;
                d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{run: '0, lock: 1'b0, thr: 2'd0};
        else        q <= d;
    end

    assign run_cnt = q.run;
    assign lock    = q.lock;
endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch
    import pll_lock_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_in,
    input  logic             fb_clk_in,
    input  logic             enable,
    input  logic [1:0]       thr_sel,
    input  logic [WIN_W-1:0] win_cycles,
    input  logic [2:0]       route_en,
    output logic             lock_o,
    output logic             lock_pin,
    output logic             status_pin,
    output logic             monitor_pin
);
    logic             ref_rise, fb_rise;
    logic             vrd_valid, vrd_pass;
    logic [RUN_W-1:0] run_cnt;
    logic [PIN_COUNT-1:0] pins_w;

    edge_sync u_ref_sync (.clk(clk), .rst_n(rst_n), .async_in(ref_clk_in), .rise_o(ref_rise));
    edge_sync u_fb_sync  (.clk(clk), .rst_n(rst_n), .async_in(fb_clk_in),  .rise_o(fb_rise));

    phase_window_meter #(.WIN_W(WIN_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (ref_rise),
        .fb_rise   (fb_rise),
        .win_cycles(win_cycles),
        .vrd_valid (vrd_valid),
        .vrd_pass  (vrd_pass)
    );

    run_qualifier u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .thr_sel  (thr_sel),
        .vrd_valid(vrd_valid),
        .vrd_pass (vrd_pass),
        .run_cnt  (run_cnt),
        .lock     (lock_o)
    );

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_route
        assign pins_w[p] = lock_o & route_en[p];
    end

    assign lock_pin    = pins_w[PIN_LOCK];
    assign status_pin  = pins_w[PIN_STATUS];
    assign monitor_pin = pins_w[PIN_MONITOR];
endmodule

// File: rtl/pll_lock_watch_chk.sv
module pll_lock_watch_chk
    import pll_lock_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [1:0]       thr_sel,
    input logic             lock_o,
    input logic             vrd_valid,
    input logic             vrd_pass,
    input logic [RUN_W-1:0] run_cnt
);
    assert_fail_drops_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && vrd_valid && !vrd_pass) |=> !lock_o);

    assert_disable_holds_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !lock_o);

    assert_lock_rise_after_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(vrd_valid && vrd_pass));

    assert_run_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(thr_sel) |-> (run_cnt <= run_target(thr_sel)));

    assert_thr_change_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_sel != $past(thr_sel)) |=> !lock_o);
endmodule

bind pll_lock_watch pll_lock_watch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .thr_sel  (thr_sel),
    .lock_o   (lock_o),
    .vrd_valid(vrd_valid),
    .vrd_pass (vrd_pass),
    .run_cnt  (run_cnt)
);

// File: tb/pll_lock_watch_test.sv
module pll_lock_watch_test;
    localparam int WIN_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_clk_in = 1'b0;
    logic             fb_clk_in = 1'b0;
    logic             enable = 1'b0;
    logic [1:0]       thr_sel = 2'd0;
    logic [WIN_W-1:0] win_cycles = 6'd4;
    logic [2:0]       route_en = 3'b111;
    logic             lock_o, lock_pin, status_pin, monitor_pin;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_lock_watch #(.WIN_W(WIN_W)) uut (
        .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .fb_clk_in(fb_clk_in),
        .enable(enable), .thr_sel(thr_sel), .win_cycles(win_cycles), .route_en(route_en),
        .lock_o(lock_o), .lock_pin(lock_pin), .status_pin(status_pin), .monitor_pin(monitor_pin)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One edge pair: leader rises, partner rises sep cycles later, then a quiet gap.
    task automatic pair(input bit lead_ref, input int sep);
        @(negedge clk);
        if (sep == 0) begin
            ref_clk_in = 1'b1; fb_clk_in = 1'b1;
        end else begin
            if (lead_ref) ref_clk_in = 1'b1; else fb_clk_in = 1'b1;
            idle(sep);
            if (lead_ref) fb_clk_in = 1'b1; else ref_clk_in = 1'b1;
        end
        idle(2);
        ref_clk_in = 1'b0; fb_clk_in = 1'b0;
        idle(2 * int'(win_cycles) + 8);
    endtask

    function automatic int target(input logic [1:0] c);
        case (c)
            2'd0: return 5;
            2'd1: return 16;
            2'd2: return 64;
            default: return 255;
        endcase
    endfunction

    initial begin
        idle(3);
        // R1: reset state
        check("R1 lock", lock_o, 1'b0);
        check("R1 pins", lock_pin | status_pin | monitor_pin, 1'b0);
        rst_n = 1'b1;
        enable = 1'b1;
        idle(4);
        check("R1 after release", lock_o, 1'b0);

        // R2 / R9: window sweep with lock held before each probe pair
        foreach (win_cycles_set[w]) begin
            win_cycles = win_cycles_set[w];
            for (int lead = 0; lead < 2; lead++) begin
                for (int sep = 0; sep <= 2 * int'(win_cycles) + 2; sep++) begin
                    for (int k = 0; k < 5; k++) pair(1'b1, 0);
                    check("R9 simultaneous pairs lock", lock_o, 1'b1);
                    pair(lead[0], sep);
                    check($sformatf("R2 win=%0d lead_ref=%0d sep=%0d", win_cycles, lead, sep),
                          lock_o, (sep < int'(win_cycles)));
                end
            end
        end
        win_cycles = 6'd4;

        // R3 / R7: threshold sweep over all codes
        for (int c = 3; c >= 0; c--) begin
            for (int k = 0; k < 5; k++) pair(1'b0, 0);
            thr_sel = c[1:0];
            idle(2);
            check($sformatf("R7 code change to %0d clears", c), lock_o, 1'b0);
            for (int k = 0; k < target(c[1:0]) - 1; k++) pair(k[0], k % 4);
            check($sformatf("R3 code %0d one short", c), lock_o, 1'b0);
            pair(1'b1, 1);
            check($sformatf("R3 code %0d reached", c), lock_o, 1'b1);
            pair(1'b0, 3);
            check($sformatf("R3 code %0d stays locked", c), lock_o, 1'b1);
        end
        thr_sel = 2'd0;
        idle(2);

        // R4: single failing pair after long locked run
        for (int k = 0; k < 8; k++) pair(1'b1, 2);
        check("R4 locked before fail", lock_o, 1'b1);
        pair(1'b0, 4);
        check("R4 one fail clears", lock_o, 1'b0);
        for (int k = 0; k < 4; k++) pair(1'b1, 0);
        check("R4 run restarted from zero", lock_o, 1'b0);
        pair(1'b1, 0);
        check("R4 relock", lock_o, 1'b1);

        // R5: orphan leading edge times out
        @(negedge clk);
        ref_clk_in = 1'b1;
        idle(3 * int'(win_cycles) + 10);
        check("R5 orphan ref edge clears", lock_o, 1'b0);
        ref_clk_in = 1'b0;
        idle(4);
        for (int k = 0; k < 5; k++) pair(1'b0, 0);
        @(negedge clk);
        fb_clk_in = 1'b1;
        idle(3 * int'(win_cycles) + 10);
        check("R5 orphan fb edge clears", lock_o, 1'b0);
        fb_clk_in = 1'b0;
        idle(4);

        // R6: enable
        for (int k = 0; k < 5; k++) pair(1'b0, 1);
        check("R6 locked while enabled", lock_o, 1'b1);
        enable = 1'b0;
        idle(2);
        check("R6 disabled low", lock_o, 1'b0);
        for (int k = 0; k < 5; k++) pair(1'b1, 0);
        check("R6 pairs ignored while disabled", lock_o, 1'b0);
        enable = 1'b1;
        for (int k = 0; k < 4; k++) pair(1'b1, 0);
        check("R6 run cleared by disable", lock_o, 1'b0);
        pair(1'b1, 0);
        check("R6 relock after enable", lock_o, 1'b1);

        // R8: routing, locked then unlocked
        for (int r = 0; r < 8; r++) begin
            route_en = r[2:0];
            @(negedge clk);
            check($sformatf("R8 lock_pin r=%0d", r), lock_pin, r[0]);
            check($sformatf("R8 status_pin r=%0d", r), status_pin, r[1]);
            check($sformatf("R8 monitor_pin r=%0d", r), monitor_pin, r[2]);
        end
        pair(1'b0, 5);
        route_en = 3'b111;
        @(negedge clk);
        check("R8 pins low when unlocked", lock_pin | status_pin | monitor_pin, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    logic [WIN_W-1:0] win_cycles_set [2] = '{6'd3, 6'd5};

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule